// File: doc/BRIEF.md
# E3 Line Encoder

This block turns a serial NRZ transmit bit stream into the two rail signals that drive an E3 line interface: a positive rail and a negative rail. Each bit is sampled on the rising edge of the transmit line clock. The block has three line codes, chosen by host control bits. The first is unipolar single-rail. The second is bipolar alternate mark inversion (AMI). The third is bipolar HDB3, which removes long zero runs by inserting coded pulses.

A four-stage look-ahead pipeline holds every bit before it is emitted, so that a run of four zeros is known before its first zero leaves. The same pipeline is used in every mode, so the latency is the same whatever code is active. A further control bit chooses which edge of the line clock launches the rail outputs. The falling-edge choice gives the downstream line driver half a clock of extra setup margin.

A high level on the positive rail marks a positive pulse. A high level on the negative rail marks a negative pulse. Both rails low means no pulse.

Top module: `e3_line_encoder`

## Requirements
- R1: While rst_n is low, both rails are low, the look-ahead pipeline is empty and the polarity state is cleared. The first pulse after reset is positive (line_pos high) in the AMI and HDB3 modes.
- R2: In rising-edge launch (cfg_fall_edge=0), a bit sampled on rising edge k drives the rails from rising edge k+4. For the first four clocks after reset, both rails stay low.
- R3: With cfg_unipolar=1, line_pos equals the delayed data bit and line_neg stays low, and cfg_ami has no effect on either rail.
- R4: With cfg_unipolar=0 and cfg_ami=1 (AMI), each 1 produces a pulse on the rail opposite to the previous pulse, and each 0 leaves both rails low.
- R5: With cfg_unipolar=0 and cfg_ami=0 (HDB3), 1 bits alternate polarity as in AMI. Every run of four zeros is replaced by a substitution pattern.
- R6: In HDB3, if the number of pulses since the last violation is odd, four zeros are sent as 000V. V is a pulse with the same polarity as the pulse before it.
- R7: In HDB3, if that count is even (it is even after reset), four zeros are sent as B00V. B is a normal alternating pulse and V repeats the polarity of B.
- R8: line_pos and line_neg are never high together.
- R9: With cfg_fall_edge=1, the rails change only on falling edges. They carry the same sequence half a clock later than in rising-edge launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_data | input | 1 | Serial NRZ transmit data, sampled on the rising edge |
| cfg_unipolar | input | 1 | 1 selects single-rail output and overrides cfg_ami |
| cfg_ami | input | 1 | In bipolar mode, 1 selects AMI and 0 selects HDB3 |
| cfg_fall_edge | input | 1 | 1 launches the rails on the falling clock edge |
| line_pos | output | 1 | Positive rail (unipolar data in single-rail mode) |
| line_neg | output | 1 | Negative rail |

## Verification
The unipolar mode is driven twice with the same pattern, once with cfg_ami low and once high, to show that the AMI/HDB3 select has no effect there. The AMI mode uses a pattern of back-to-back ones and an isolated four-zero run, which separates true alternation from a substitution wrongly applied outside HDB3. The HDB3 mode uses one stream whose zero runs follow odd and then even pulse counts, so that both 000V and B00V occur, together with a stream that starts with zeros straight after reset to show the even initial count and the positive first pulse. The HDB3 and AMI streams are repeated with falling-edge launch, sampling both just after the rising edge and mid-cycle, which shows which edge moved the rails.

// File: rtl/e3_enc_pkg.sv
package e3_enc_pkg;

  typedef enum logic [1:0] {
    MODE_UNI  = 2'd0,
    MODE_AMI  = 2'd1,
    MODE_HDB3 = 2'd2
  } line_mode_t;

  // One look-ahead slot: occupied flag, data bit, violation tag
  typedef struct packed {
    logic vld;
    logic dat;
    logic vtag;
  } la_slot_t;

  function automatic line_mode_t decode_mode(input logic uni, input logic ami);
    if (uni)      return MODE_UNI;
    else if (ami) return MODE_AMI;
    else          return MODE_HDB3;
  endfunction

endpackage

// File: rtl/e3_lookahead.sv
module e3_lookahead
  import e3_enc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic sub_en,
  output logic head_vld,
  output logic head_dat,
  output logic head_vtag,
  output logic run_hit
);

  la_slot_t slot_q [DEPTH];
  la_slot_t slot_d [DEPTH];

  // A full window of untagged zeros starts a substitution at the head
  always_comb begin
    run_hit = sub_en;
    for (int i = 0; i < DEPTH; i++) begin
      run_hit = run_hit & slot_q[i].vld & ~slot_q[i].dat & ~slot_q[i].vtag;
    end
  end

  always_comb begin
    slot_d[0] = '{vld: 1'b1, dat: din, vtag: 1'b0};
    for (int i = 1; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i-1];
    end
    // newest zero of the detected run becomes the violation slot
    if (run_hit) slot_d[1].vtag = 1'b1;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q[g] <= '0;
        else        slot_q[g] <= slot_d[g];
      end
    end
  endgenerate

  assign head_vld  = slot_q[DEPTH-1].vld;
  assign head_dat  = slot_q[DEPTH-1].dat;
  assign head_vtag = slot_q[DEPTH-1].vtag;

  // R5
  tag_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit |=> slot_q[1].vtag);

endmodule

// File: rtl/e3_pulse_gen.sv
module e3_pulse_gen
  import e3_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_mode_t mode,
  input  logic       head_vld,
  input  logic       head_dat,
  input  logic       head_vtag,
  input  logic       run_hit,
  output logic       enc_pos,
  output logic       enc_neg
);

  logic last_pos_q, last_pos_d;   // polarity of last emitted pulse (1 = positive)
  logic par_q, par_d;             // odd count of pulses since last violation
  logic pos_q, pos_d, neg_q, neg_d;
  logic mark;

  assign mark = head_vld & head_dat;

  always_comb begin
    pos_d      = 1'b0;
    neg_d      = 1'b0;
    last_pos_d = last_pos_q;
    par_d      = par_q;
    unique case (mode)
      MODE_UNI: begin
        pos_d = mark;
      end
      MODE_AMI: begin
        if (mark) begin
          pos_d      = ~last_pos_q;
          neg_d      = last_pos_q;
          last_pos_d = ~last_pos_q;
        end
      end
      default: begin
        if (head_vtag) begin
          pos_d = last_pos_q;
          neg_d = ~last_pos_q;
          par_d = 1'b0;
        end else if ((run_hit & ~par_q) | mark) begin
          pos_d      = ~last_pos_q;
          neg_d      = last_pos_q;
          last_pos_d = ~last_pos_q;
          par_d      = ~par_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      par_q      <= 1'b0;
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
    end else begin
      last_pos_q <= last_pos_d;
      par_q      <= par_d;
      pos_q      <= pos_d;
      neg_q      <= neg_d;
    end
  end

  assign enc_pos = pos_q;
  assign enc_neg = neg_q;

  // R3
  uni_neg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UNI) |=> !neg_q);

  // R4
  ami_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AMI && head_vld) |=> ((pos_q | neg_q) == $past(head_dat)));

  // R6
  hdb3_viol_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HDB3 && head_vtag) |=> (pos_q == $past(last_pos_q)) && (neg_q != pos_q));

endmodule

// File: rtl/e3_edge_launch.sv
module e3_edge_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_sel,
  input  logic pos_in,
  input  logic neg_in,
  output logic pos_out,
  output logic neg_out
);

  logic pos_fq, neg_fq;

  // retime rising-edge rails onto the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_fq <= 1'b0;
      neg_fq <= 1'b0;
    end else begin
      pos_fq <= pos_in;
      neg_fq <= neg_in;
    end
  end

  assign pos_out = fall_sel ? pos_fq : pos_in;
  assign neg_out = fall_sel ? neg_fq : neg_in;

  // R8
  no_dual_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

endmodule

// File: rtl/e3_line_encoder.sv
module e3_line_encoder
  import e3_enc_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_data,
  input  logic cfg_unipolar,
  input  logic cfg_ami,
  input  logic cfg_fall_edge,
  output logic line_pos,
  output logic line_neg
);

  localparam int LA_DEPTH = RUN_LEN;

  line_mode_t mode;
  logic head_vld, head_dat, head_vtag, run_hit;
  logic enc_pos, enc_neg;

  assign mode = decode_mode(cfg_unipolar, cfg_ami);

  e3_lookahead #(.DEPTH(LA_DEPTH)) u_lookahead (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (tx_data),
    .sub_en    (mode == MODE_HDB3),
    .head_vld  (head_vld),
    .head_dat  (head_dat),
    .head_vtag (head_vtag),
    .run_hit   (run_hit)
  );

  e3_pulse_gen u_pulse_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .head_vld  (head_vld),
    .head_dat  (head_dat),
    .head_vtag (head_vtag),
    .run_hit   (run_hit),
    .enc_pos   (enc_pos),
    .enc_neg   (enc_neg)
  );

  e3_edge_launch u_edge_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_sel (cfg_fall_edge),
    .pos_in   (enc_pos),
    .neg_in   (enc_neg),
    .pos_out  (line_pos),
    .neg_out  (line_neg)
  );

endmodule

// File: tb/e3_line_encoder_bench.sv
module e3_line_encoder_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tx_data, cfg_unipolar, cfg_ami, cfg_fall_edge;
  logic line_pos, line_neg;

  e3_line_encoder u_e3_line_encoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_data       (tx_data),
    .cfg_unipolar  (cfg_unipolar),
    .cfg_ami       (cfg_ami),
    .cfg_fall_edge (cfg_fall_edge),
    .line_pos      (line_pos),
    .line_neg      (line_neg)
  );

  logic [1:0] exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    edge_cnt = 0;
  string seg_tag = "R1";
  logic [1:0] prev_exp;
  bit    m_last_pos, m_par;
  int    m_zrun;

  task automatic check(input bit ok, input string rq, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: rails got %b expected %b at %0t", rq, got, exp, $time);
    end
  endtask

  // scoreboard model: pushes the expected rail pair for each driven bit
  task automatic push_bit(input bit b);
    if (cfg_unipolar) begin
      exp_q.push_back({b, 1'b0});
    end else if (cfg_ami) begin
      if (b) begin
        m_last_pos = !m_last_pos;
        exp_q.push_back({m_last_pos, !m_last_pos});
      end else exp_q.push_back(2'b00);
    end else begin
      if (b) begin
        m_last_pos = !m_last_pos;
        exp_q.push_back({m_last_pos, !m_last_pos});
        m_par  = !m_par;
        m_zrun = 0;
      end else begin
        m_zrun++;
        if (m_zrun == 4) begin
          if (!m_par) begin  // B00V: rewrite first zero of the run
            m_last_pos = !m_last_pos;
            exp_q[exp_q.size()-3] = {m_last_pos, !m_last_pos};
          end
          exp_q.push_back({m_last_pos, !m_last_pos});
          m_par  = 1'b0;
          m_zrun = 0;
        end else exp_q.push_back(2'b00);
      end
    end
  endtask

  task automatic drive_bit(input bit b);
    tx_data = b;
    push_bit(b);
    @(negedge clk);
  endtask

  task automatic run_seg(input bit uni, input bit ami, input bit fall, input string tag,
                         input logic [31:0] pat, input int n);
    @(negedge clk);
    rst_n         = 1'b0;
    tx_data       = 1'b0;
    cfg_unipolar  = uni;
    cfg_ami       = ami;
    cfg_fall_edge = fall;
    exp_q.delete();
    m_last_pos = 1'b0;
    m_par      = 1'b0;
    m_zrun     = 0;
    seg_tag    = tag;
    @(negedge clk);
    @(negedge clk);
    check({line_pos, line_neg} == 2'b00, "R1 reset", {line_pos, line_neg}, 2'b00);
    rst_n = 1'b1;
    for (int i = n - 1; i >= 0; i--) drive_bit(pat[i]);
    for (int i = 0; i < 6; i++) drive_bit(1'b0);
  endtask

  // monitor: samples just after the rising edge and mid-cycle
  always begin
    logic [1:0] early, late, e;
    @(posedge clk);
    if (!rst_n) begin
      edge_cnt = 0;
      prev_exp = 2'b00;
    end else edge_cnt++;
    #2;
    early = {line_pos, line_neg};
    #6;
    late = {line_pos, line_neg};
    if (rst_n) begin
      if (edge_cnt >= 1 && edge_cnt < 5) begin
        check(late == 2'b00, "R2 latency", late, 2'b00);
      end else if (edge_cnt >= 5 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(late == e, seg_tag, late, e);
        check(late != 2'b11, "R8 exclusive rails", late, e);
        if (cfg_fall_edge) check(early == prev_exp, "R9 falling launch", early, prev_exp);
        else               check(early == e, "R9 rising launch", early, e);
        prev_exp = e;
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_data = 1'b0;
    cfg_unipolar = 1'b0; cfg_ami = 1'b0; cfg_fall_edge = 1'b0;
    // unipolar, then again with the AMI/HDB3 select flipped (ignored)
    run_seg(1, 0, 0, "R3 unipolar", 32'b101100001, 9);
    run_seg(1, 1, 0, "R3 unipolar ami-ignored", 32'b101100001, 9);
    // AMI alternation, zero run left untouched
    run_seg(0, 1, 0, "R4 ami", 32'b1101000011, 10);
    // HDB3: odd count -> 000V, even -> B00V, then both again
    run_seg(0, 0, 0, "R5 R6 R7 hdb3", 32'b100001100001000000001, 21);
    // HDB3 starting with zeros: even count after reset, first pulse positive
    run_seg(0, 0, 0, "R1 R7 hdb3 start", 32'b00000000101, 11);
    // falling-edge launch
    run_seg(0, 0, 1, "R9 R6 R7 hdb3 fall", 32'b100001100001000000001, 21);
    run_seg(0, 1, 1, "R9 R4 ami fall", 32'b1101000011, 10);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule